// File: doc/BRIEF.md
# Line Sensor Readout Timing Generator

This block is the digital sequencing core of a 128-channel linear photodiode readout stage. It is clocked on the falling edge of an external sensor clock. From a line reset pulse it derives two things. The first is an integration window flag that trails each reset edge by a fixed number of clocks. The second is a readout scan that steps through the channels one at a time, four clocks per channel. During the scan the block presents a channel index with a valid flag, issues a one-clock strobe per channel and ends with an active-low end-of-scan pulse. The index and strobe take the place of the analog video output, whose levels are not modelled here.

A stage in leader mode starts its scan from the falling edge of the line reset. A stage in follower mode ignores the reset for this purpose and starts from a falling edge on its external start input. Feeding a leader's end-of-scan output into a follower's start input joins two stages into one serial scan of twice the channel count, with no gap between the halves. A line reset that rises while a scan is in progress breaks the timing rules. The block records this in a sticky error flag and lets the scan finish.

Top module: `linescan_timer`

## Requirements
- R1: While `por_n` is low, and on the first clock after it is released, the outputs are `trig`=0, `chan_valid`=0, `chan_idx`=0, `eos_n`=1, `integ_win`=0 and `seq_err`=0.
- R2: In leader mode (`master_sel`=1), a scan begins on the first falling clock edge that samples `line_rst` low after it was high. That edge counts as clock 1, where clock k is the interval after falling edge k. `chan_valid` first rises in clock 19 with `chan_idx`=0.
- R3: Channel c (0 to N_CH-1) occupies clocks 19+4c through 22+4c with `chan_valid`=1 and `chan_idx`=c. Outside the scan, `chan_valid`=0 and `chan_idx`=0.
- R4: `trig` is high for exactly one clock per channel: the third clock of its slot (clock 21+4c), and never outside a slot.
- R5: `eos_n` is low for exactly one clock, clock 18+4·N_CH, which is the last clock of the last slot. `chan_valid` is 0 from the next clock on.
- R6: `integ_win` rises in the 8th clock after a rising edge of `line_rst` and falls in the 8th clock after a falling edge, counting the first sampling edge as clock 1.
- R7: In follower mode (`master_sel`=0), the first falling clock edge that samples `ext_start` low after it was high starts the scan directly at channel 0. Channel c is then valid in clocks 1+4c through 4+4c after that edge, so a follower fed by a leader's `eos_n` continues the leader's scan seamlessly as channels N_CH to 2·N_CH-1.
- R8: A falling `line_rst` does not start a follower, and `ext_start` does not start a leader.
- R9: A rising `line_rst` sampled during a scan sets `seq_err` one edge later. That scan and its timing are unchanged, and a falling `line_rst` during a scan does not restart it.
- R10: `seq_err` stays set through later scans and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor clock; all state advances on its falling edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| line_rst | input | 1 | Line reset pulse; sets integration and starts a leader scan |
| ext_start | input | 1 | Scan start for follower mode, active on falling edge |
| master_sel | input | 1 | 1 = leader, 0 = follower |
| trig | output | 1 | One-clock per-channel sample strobe |
| chan_idx | output | $clog2(N_CH) | Channel currently presented |
| chan_valid | output | 1 | High while a channel slot is presented |
| integ_win | output | 1 | Integration window flag |
| eos_n | output | 1 | End-of-scan pulse, active low |
| seq_err | output | 1 | Sticky flag: reset rose during a scan |

## Verification
A wrong scan counter shows at the ports in the clock where it goes wrong. `chan_valid` rises off clock 19, the index moves within a slot, or `trig` leaves the third clock of the slot. All of these are compared every clock over full scans. A wrong end count misplaces `eos_n`, and in a two-stage chain it also shifts the follower's whole scan. A stale reset history shows up as an integration window misplaced by a clock, or as an error flag that sets or clears at the wrong time. Both are observed within ten clocks of the reset edge.

// File: rtl/linescan_timer.sv
module linescan_timer #(
  parameter int N_CH       = 128,
  parameter int FIRST_SLOT = 19,
  parameter int INTEG_LAG  = 8
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    line_rst,
  input  logic                    ext_start,
  input  logic                    master_sel,
  output logic                    trig,
  output logic [$clog2(N_CH)-1:0] chan_idx,
  output logic                    chan_valid,
  output logic                    integ_win,
  output logic                    eos_n,
  output logic                    seq_err
);
  localparam int SLOT = 4;
  localparam int CHW  = $clog2(N_CH);
  localparam int LAST = FIRST_SLOT + SLOT * N_CH - 1;
  localparam int CW   = $clog2(LAST + 2);

  logic [INTEG_LAG-1:0] rst_hist;
  logic                 ext_q;
  logic                 running;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        off;

  wire rst_rise = line_rst & ~rst_hist[0];
  wire rst_fall = ~line_rst & rst_hist[0];
  wire ext_fall = ~ext_start & ext_q;
  wire start    = ~running & (master_sel ? rst_fall : ext_fall);

  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_hist <= '0;
      ext_q    <= 1'b1;
      running  <= 1'b0;
      cnt      <= '0;
      seq_err  <= 1'b0;
    end else begin
      rst_hist <= {rst_hist[INTEG_LAG-2:0], line_rst};
      ext_q    <= ext_start;
      if (start) begin
        running <= 1'b1;
        cnt     <= master_sel ? CW'(1) : CW'(FIRST_SLOT);
      end else if (running) begin
        if (cnt == CW'(LAST)) begin
          running <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (running && rst_rise) seq_err <= 1'b1;
    end
  end

  assign off        = cnt - CW'(FIRST_SLOT);
  assign chan_valid = running && (cnt >= CW'(FIRST_SLOT));
  assign chan_idx   = chan_valid ? off[CHW+1:2] : '0;
  assign trig       = chan_valid && (off[1:0] == 2'd2);
  assign eos_n      = !(running && cnt == CW'(LAST));
  assign integ_win  = rst_hist[INTEG_LAG-1];

  // R4
  trig_in_slot_chk: assert property (@(negedge clk) disable iff (!por_n)
    trig |-> chan_valid);
  // R4
  trig_single_chk: assert property (@(negedge clk) disable iff (!por_n)
    trig |=> !trig);
  // R5
  eos_last_chk: assert property (@(negedge clk) disable iff (!por_n)
    !eos_n |-> (chan_valid && chan_idx == CHW'(N_CH - 1)));
  // R5
  eos_end_chk: assert property (@(negedge clk) disable iff (!por_n)
    !eos_n |=> !chan_valid);
  // R3
  chan_step_chk: assert property (@(negedge clk) disable iff (!por_n)
    (chan_valid && $past(chan_valid) && chan_idx != $past(chan_idx))
      |-> chan_idx == $past(chan_idx) + 1'b1);
  // R9
  err_set_chk: assert property (@(negedge clk) disable iff (!por_n)
    (running && line_rst && !rst_hist[0]) |=> seq_err);
endmodule

// File: tb/linescan_timer_tb.sv
`timescale 1ns/1ps
module linescan_timer_tb;
  localparam int N    = 128;
  localparam int F    = 19;
  localparam int LAST = F + 4 * N - 1;
  localparam int CHW  = $clog2(N);

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic line_rst = 1'b0;
  logic m_ext = 1'b1;
  logic m_trig, m_valid, m_integ, m_eos_n, m_err;
  logic s_trig, s_valid, s_integ, s_eos_n, s_err;
  logic [CHW-1:0] m_idx, s_idx;
  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  linescan_timer #(.N_CH(N)) u_dut (
    .clk(clk), .por_n(por_n), .line_rst(line_rst), .ext_start(m_ext),
    .master_sel(1'b1), .trig(m_trig), .chan_idx(m_idx), .chan_valid(m_valid),
    .integ_win(m_integ), .eos_n(m_eos_n), .seq_err(m_err));

  linescan_timer #(.N_CH(N)) u_slv (
    .clk(clk), .por_n(por_n), .line_rst(line_rst), .ext_start(m_eos_n),
    .master_sel(1'b0), .trig(s_trig), .chan_idx(s_idx), .chan_valid(s_valid),
    .integ_win(s_integ), .eos_n(s_eos_n), .seq_err(s_err));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_outputs(input string req);
    chk({req, " leader trig"}, m_trig, 0);
    chk({req, " leader valid"}, m_valid, 0);
    chk({req, " leader idx"}, m_idx, 0);
    chk({req, " leader eos_n"}, m_eos_n, 1);
    chk({req, " follower valid"}, s_valid, 0);
    chk({req, " follower eos_n"}, s_eos_n, 1);
  endtask

  // R1 / R10: power-on reset state and clearing of the error flag
  task automatic t_por();
    por_n = 1'b0;
    line_rst = 1'b0;
    repeat (3) step();
    idle_outputs("R1 in reset");
    chk("R1 integ", m_integ, 0);
    chk("R1 seq_err", m_err, 0);
    chk("R10 seq_err cleared by por", m_err, 0);
    por_n = 1'b1;
    step();
    idle_outputs("R1 after release");
    chk("R1 seq_err after release", m_err, 0);
    repeat (10) step();
  endtask

  // R2..R7, R9: one reset pulse and the chained scan that follows
  task automatic t_frame(input int high_clks, input bit inject, input int exp_err);
    line_rst = 1'b1;
    for (int k = 1; k <= high_clks; k++) begin
      step();
      chk("R6 window after rise", m_integ, (k >= 8) ? 1 : 0);
    end
    line_rst = 1'b0;
    for (int k = 1; k <= LAST + 4 * N + 4; k++) begin
      int ev, ec, et, ee, sv, sc, st, se, d;
      step();
      ev = (k >= F && k <= LAST) ? 1 : 0;
      ec = ev ? (k - F) / 4 : 0;
      et = (ev && ((k - F) % 4) == 2) ? 1 : 0;
      ee = (k == LAST) ? 0 : 1;
      d  = k - LAST - 1;
      sv = (d >= 0 && d < 4 * N) ? 1 : 0;
      sc = sv ? d / 4 : 0;
      st = (sv && (d % 4) == 2) ? 1 : 0;
      se = (d == 4 * N - 1) ? 0 : 1;
      if (k <= 10) chk("R6 window after fall", m_integ, (k < 8) ? 1 : 0);
      chk(k < F ? "R2 leader valid" : "R3 leader valid", m_valid, ev);
      chk("R3 leader index", m_idx, ec);
      chk("R4 leader trig", m_trig, et);
      chk("R5 leader eos_n", m_eos_n, ee);
      chk(k <= LAST ? "R8 follower ignores reset" : "R7 follower valid", s_valid, sv);
      chk("R7 follower index", s_idx, sc);
      chk("R7 follower trig", s_trig, st);
      chk("R7 follower eos_n", s_eos_n, se);
      if (ev || sv)
        chk("R7 chained index", ev ? m_idx : N + s_idx, (k - F) / 4);
      if (inject && k == 40) line_rst = 1'b1;
      if (inject && k == 60) line_rst = 1'b0;
      if (inject && k == 41) chk("R9 error sets one edge after rise", m_err, 1);
    end
    chk(inject ? "R9 seq_err" : "R10 seq_err", m_err, exp_err);
    chk("R9 follower seq_err", s_err, 0);
    repeat (4) step();
  endtask

  // R8: ext_start has no effect on a leader
  task automatic t_leader_ignores_ext();
    int seen = 0;
    m_ext = 1'b0;
    repeat (3) step();
    m_ext = 1'b1;
    for (int k = 0; k < 30; k++) begin
      step();
      if (m_valid || !m_eos_n || m_trig) seen = 1;
    end
    chk("R8 leader ignores ext_start", seen, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_por();
    t_frame(20, 1'b0, 0);
    t_frame(12, 1'b1, 1);
    t_frame(30, 1'b0, 1);
    t_leader_ignores_ext();
    t_por();
    t_frame(9, 1'b0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule